// File: doc/BRIEF.md
# Ring-Aware Address Translation Buffer

This block translates virtual addresses for a core. It keeps separate instruction and data translation buffers. Each buffer has several associative ways, and each way has a small directly indexed table. An entry holds a virtual page number, a physical page number, an 8-bit address-space identifier and a 4-bit attribute.

A lookup presents a virtual address, an access kind and the privilege index of the requester. One cycle later the block returns the following:
- the way and index that was consulted;
- the ring that owns the entry;
- the decoded read/write/execute permissions;
- the translated physical address and the page size;
- the page-table-entry address that a refill would fetch;
- a cause code, which is zero when the access may proceed.

A ring register holds one address-space identifier per ring. The ring of an entry is found by searching this register for the entry's identifier.

Refills come from an outside walker that has already fetched the page-table word. The block picks the victim way by advancing a rotating counter. It takes the ring from the fetched word and stores the identifier that the ring register currently assigns to that ring.

Top module: `tlb_ring_xlate`

## Requirements
- R1: After reset the ring register reads as 0x04030201 (byte i is the identifier of ring i) and the refill counter is 0. Every entry holds identifier 0, so every lookup misses. rsp_valid is low.
- R2: An entry hits when its stored virtual page equals the address's page (bits 31:12) and its identifier is nonzero. Its ring is the lowest byte index of the ring register that equals the identifier, or 3 when no byte matches.
- R3: With no hitting way the cause is 1 for a fetch and 5 for a load or store. With two or more hitting ways it is 2 for a fetch and 6 for a load or store. On a multi-hit, rsp_way and rsp_ring come from the lowest-numbered hitting way and rsp_perm is 0.
- R4: For a single hit whose ring is numerically below lk_priv, the cause is 3 for a fetch and 7 for a load or store.
- R5: rsp_perm holds {read, write, execute} in bits 2,1,0 for a single hit. An attribute below 12 grants read, with write equal to attribute bit 1 and execute equal to attribute bit 0. Attribute 13 grants read and write. Attributes 12, 14 and 15 grant nothing.
- R6: lk_acc 0 or 3 is a load and needs read. lk_acc 1 is a store and needs write. lk_acc 2 is a fetch and needs execute. A denial gives cause 8, 9 or 4 respectively; this check comes after the privilege check. Cause 0 sets rsp_ok.
- R7: On success, rsp_paddr is the entry's physical page ORed with address bits 11:0, and rsp_page_size is 4096 (inverted page mask plus one). On any failure both are 0.
- R8: rsp_pte_addr is the page-table base register ORed with the virtual address shifted right by 10, with bits 1:0 cleared. The base register is loaded by ptev_we and resets to 0.
- R9: Each refill first increments the counter and then writes the way given by its low two bits, at index = virtual page bits 1:0. It stores the page from vaddr[31:12], the physical page from pte[31:12], the attribute from pte[3:0] and the ring-register byte selected by pte[5:4]. rsp_idx reports the page bits 1:0.
- R10: Fetches (lk_acc 2) consult only the instruction buffer; other lookups consult only the data buffer. refill_is_data picks the buffer a refill writes.
- R11: The response is registered: a lookup presented at one clock edge is answered after that edge, and rsp_valid is a one-cycle pulse per lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_we | input | 1 | Load the ring register |
| ring_wdata | input | 32 | New ring register value, byte i for ring i |
| ptev_we | input | 1 | Load the page-table base register |
| ptev_wdata | input | 32 | New page-table base |
| refill_valid | input | 1 | Write one refilled entry |
| refill_is_data | input | 1 | 1 writes the data buffer, 0 the instruction buffer |
| refill_vaddr | input | 32 | Virtual address being refilled |
| refill_pte | input | 32 | Fetched page-table word |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0/3 load, 1 store, 2 fetch |
| lk_priv | input | 2 | Privilege index of the requester |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Access allowed (cause 0) |
| rsp_cause | output | 4 | Cause code |
| rsp_way | output | 2 | Way selected |
| rsp_idx | output | 2 | Entry index consulted |
| rsp_ring | output | 2 | Ring of the selected entry |
| rsp_perm | output | 3 | Read, write, execute permissions |
| rsp_paddr | output | 32 | Physical address |
| rsp_page_size | output | 32 | Page size in bytes |
| rsp_pte_addr | output | 32 | Page-table-entry address for a refill |

## Verification
A corrupted identifier or ring register shows up at the first lookup that touches the affected entry. The symptom is a wrong ring, a spurious privilege cause, or a miss where a hit was due, all visible in the next response. A refill counter that drifts shows up as a wrong rsp_way on the lookup that follows the refill. A bad attribute or page field shows up in the same response as wrong permissions, a wrong denial code or a wrong physical page. The table of lookups covers both buffers and every cause. The directed cases rewrite the ring register, store a zero identifier, and reset with live entries.

// File: rtl/tlb_rx_pkg.sv
package tlb_rx_pkg;
  typedef enum logic [3:0] {
    CAUSE_NONE     = 4'd0,
    CAUSE_I_MISS   = 4'd1,
    CAUSE_I_MULTI  = 4'd2,
    CAUSE_I_PRIV   = 4'd3,
    CAUSE_I_DENY   = 4'd4,
    CAUSE_D_MISS   = 4'd5,
    CAUSE_D_MULTI  = 4'd6,
    CAUSE_D_PRIV   = 4'd7,
    CAUSE_LD_DENY  = 4'd8,
    CAUSE_ST_DENY  = 4'd9
  } cause_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int RINGS        = 4;
  localparam int RING_W       = 2;
  localparam int ATTR_W       = 4;
  localparam int PTE_RING_LSB = 4;
endpackage

// File: rtl/tlb_rx_way.sv
module tlb_rx_way #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int IDX_W  = 2,
  parameter int ASID_W = 8,
  parameter int ATTR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [VPN_W-1:0]  wvpn,
  input  logic [PPN_W-1:0]  wppn,
  input  logic [ASID_W-1:0] wasid,
  input  logic [ATTR_W-1:0] wattr,
  input  logic [VPN_W-1:0]  rvpn,
  output logic              hit,
  output logic [PPN_W-1:0]  rppn,
  output logic [ASID_W-1:0] rasid,
  output logic [ATTR_W-1:0] rattr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [VPN_W-1:0]  vpn_mem  [DEPTH];
  logic [PPN_W-1:0]  ppn_mem  [DEPTH];
  logic [ATTR_W-1:0] attr_mem [DEPTH];
  logic [ASID_W-1:0] asid_mem [DEPTH];

  logic [IDX_W-1:0] widx, ridx;
  assign widx = wvpn[IDX_W-1:0];
  assign ridx = rvpn[IDX_W-1:0];

  // payload fields carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (we) begin
      vpn_mem[widx]  <= wvpn;
      ppn_mem[widx]  <= wppn;
      attr_mem[widx] <= wattr;
    end
  end

  // the identifier doubles as the valid flag and is cleared on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) asid_mem[i] <= '0;
    end else if (we) begin
      asid_mem[widx] <= wasid;
    end
  end

  assign rppn  = ppn_mem[ridx];
  assign rasid = asid_mem[ridx];
  assign rattr = attr_mem[ridx];
  assign hit   = (vpn_mem[ridx] == rvpn) && (asid_mem[ridx] != '0);
endmodule

// File: rtl/tlb_rx_ringmap.sv
module tlb_rx_ringmap #(
  parameter int ASID_W = 8,
  parameter int RINGS  = 4,
  parameter int RING_W = 2
) (
  input  logic [RINGS*ASID_W-1:0] map,
  input  logic [ASID_W-1:0]       asid,
  output logic [RING_W-1:0]       ring
);
  always_comb begin
    ring = RING_W'(RINGS - 1);
    for (int i = RINGS - 1; i >= 0; i--) begin
      if (map[i*ASID_W +: ASID_W] == asid) ring = RING_W'(i);
    end
  end
endmodule

// File: rtl/tlb_rx_attr_dec.sv
module tlb_rx_attr_dec #(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  output logic [2:0]        perm
);
  always_comb begin
    if (attr < ATTR_W'(12))       perm = {1'b1, attr[1], attr[0]};
    else if (attr == ATTR_W'(13)) perm = 3'b110;
    else                          perm = 3'b000;
  end
endmodule

// File: rtl/tlb_ring_xlate.sv
module tlb_ring_xlate
  import tlb_rx_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 2,
  parameter int WAY_W  = 2,
  parameter int ASID_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ring_we,
  input  logic [4*ASID_W-1:0]     ring_wdata,
  input  logic                    ptev_we,
  input  logic [VA_W-1:0]         ptev_wdata,
  input  logic                    refill_valid,
  input  logic                    refill_is_data,
  input  logic [VA_W-1:0]         refill_vaddr,
  input  logic [VA_W-1:0]         refill_pte,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic [1:0]              lk_acc,
  input  logic [1:0]              lk_priv,
  output logic                    rsp_valid,
  output logic                    rsp_ok,
  output logic [3:0]              rsp_cause,
  output logic [WAY_W-1:0]        rsp_way,
  output logic [IDX_W-1:0]        rsp_idx,
  output logic [1:0]              rsp_ring,
  output logic [2:0]              rsp_perm,
  output logic [VA_W-1:0]         rsp_paddr,
  output logic [VA_W-1:0]         rsp_page_size,
  output logic [VA_W-1:0]         rsp_pte_addr
);
  localparam int NWAYS  = 1 << WAY_W;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int MAP_W  = RINGS * ASID_W;
  localparam logic [MAP_W-1:0] MAP_RST = MAP_W'(32'h04030201);
  localparam logic [VA_W-1:0]  PG_MASK = ~((VA_W'(1) << OFF_W) - VA_W'(1));
  localparam logic [VA_W-1:0]  PG_SIZE = ~PG_MASK + VA_W'(1);

  logic [MAP_W-1:0] ring_map_q;
  logic [VA_W-1:0]  ptev_q;
  logic [WAY_W-1:0] rot_q;

  // ---------------- refill path ----------------
  logic [WAY_W-1:0]   rf_way;
  logic [RING_W-1:0]  rf_ring;
  logic [ASID_W-1:0]  rf_asid;
  assign rf_way  = rot_q + WAY_W'(1);
  assign rf_ring = refill_pte[PTE_RING_LSB +: RING_W];
  assign rf_asid = ring_map_q[rf_ring*ASID_W +: ASID_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_map_q <= MAP_RST;
      ptev_q     <= '0;
      rot_q      <= '0;
    end else begin
      if (ring_we)      ring_map_q <= ring_wdata;
      if (ptev_we)      ptev_q     <= ptev_wdata;
      if (refill_valid) rot_q      <= rf_way;
    end
  end

  // ---------------- way arrays: side 0 instruction, side 1 data ----------------
  logic [VPN_W-1:0]  lk_vpn;
  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  logic [2*NWAYS-1:0] hit_all;
  logic [VPN_W-1:0]   ppn_all  [2*NWAYS];
  logic [ASID_W-1:0]  asid_all [2*NWAYS];
  logic [ATTR_W-1:0]  attr_all [2*NWAYS];

  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      tlb_rx_way #(
        .VPN_W(VPN_W), .PPN_W(VPN_W), .IDX_W(IDX_W),
        .ASID_W(ASID_W), .ATTR_W(ATTR_W)
      ) u_way (
        .clk   (clk),
        .rst   (rst),
        .we    (refill_valid && (refill_is_data == (s == 1)) && (rf_way == WAY_W'(w))),
        .wvpn  (refill_vaddr[VA_W-1:OFF_W]),
        .wppn  (refill_pte[VA_W-1:OFF_W]),
        .wasid (rf_asid),
        .wattr (refill_pte[ATTR_W-1:0]),
        .rvpn  (lk_vpn),
        .hit   (hit_all[s*NWAYS+w]),
        .rppn  (ppn_all[s*NWAYS+w]),
        .rasid (asid_all[s*NWAYS+w]),
        .rattr (attr_all[s*NWAYS+w])
      );
    end
  end

  // ---------------- lookup decision ----------------
  logic             is_data;
  logic [NWAYS-1:0] hv;
  logic [WAY_W-1:0] sel_way;
  logic             found, multi;
  int unsigned      sel_k;
  logic [RING_W-1:0] sel_ring;
  logic [2:0]       sel_perm;
  logic             granted;
  cause_e           cause_d;

  assign is_data = (lk_acc != ACC_FETCH);
  assign hv      = is_data ? hit_all[2*NWAYS-1:NWAYS] : hit_all[NWAYS-1:0];
  assign multi   = ($countones(hv) > 1);

  always_comb begin
    sel_way = '0;
    found   = 1'b0;
    for (int w = 0; w < NWAYS; w++) begin
      if (hv[w] && !found) begin
        sel_way = WAY_W'(w);
        found   = 1'b1;
      end
    end
  end

  assign sel_k = (is_data ? NWAYS : 0) + 32'(sel_way);

  tlb_rx_ringmap #(.ASID_W(ASID_W), .RINGS(RINGS), .RING_W(RING_W)) u_ring (
    .map  (ring_map_q),
    .asid (asid_all[sel_k]),
    .ring (sel_ring)
  );

  tlb_rx_attr_dec #(.ATTR_W(ATTR_W)) u_attr (
    .attr (attr_all[sel_k]),
    .perm (sel_perm)
  );

  always_comb begin
    case (lk_acc)
      ACC_FETCH: granted = sel_perm[0];
      ACC_STORE: granted = sel_perm[1];
      default:   granted = sel_perm[2];
    endcase
    if (!found)                cause_d = is_data ? CAUSE_D_MISS  : CAUSE_I_MISS;
    else if (multi)            cause_d = is_data ? CAUSE_D_MULTI : CAUSE_I_MULTI;
    else if (sel_ring < lk_priv) cause_d = is_data ? CAUSE_D_PRIV : CAUSE_I_PRIV;
    else if (!granted)
      cause_d = (lk_acc == ACC_FETCH) ? CAUSE_I_DENY :
                (lk_acc == ACC_STORE) ? CAUSE_ST_DENY : CAUSE_LD_DENY;
    else                       cause_d = CAUSE_NONE;
  end

  // ---------------- registered response ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_ok        <= 1'b0;
      rsp_cause     <= '0;
      rsp_way       <= '0;
      rsp_idx       <= '0;
      rsp_ring      <= '0;
      rsp_perm      <= '0;
      rsp_paddr     <= '0;
      rsp_page_size <= '0;
      rsp_pte_addr  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_ok        <= (cause_d == CAUSE_NONE);
        rsp_cause     <= cause_d;
        rsp_way       <= sel_way;
        rsp_idx       <= lk_vpn[IDX_W-1:0];
        rsp_ring      <= found ? sel_ring : '0;
        rsp_perm      <= (found && !multi) ? sel_perm : 3'b000;
        rsp_paddr     <= (cause_d == CAUSE_NONE) ?
                         ({ppn_all[sel_k], {OFF_W{1'b0}}} | (lk_vaddr & ~PG_MASK)) : '0;
        rsp_page_size <= (cause_d == CAUSE_NONE) ? PG_SIZE : '0;
        rsp_pte_addr  <= (ptev_q | (lk_vaddr >> 10)) & ~VA_W'(3);
      end
    end
  end
endmodule

// File: rtl/tlb_ring_xlate_chk.sv
module tlb_ring_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic [1:0]      lk_acc,
  input logic [1:0]      lk_priv,
  input logic            rsp_valid,
  input logic            rsp_ok,
  input logic [3:0]      rsp_cause,
  input logic [1:0]      rsp_ring,
  input logic [2:0]      rsp_perm,
  input logic [VA_W-1:0] rsp_paddr,
  input logic [VA_W-1:0] rsp_pte_addr
);
  p_rst_idle_r1: assert property (@(posedge clk) rst |=> !rsp_valid);

  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  p_ring_ok_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> (rsp_ring >= $past(lk_priv)));

  p_ring_low_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_cause == 4'd3 || rsp_cause == 4'd7)) |-> (rsp_ring < $past(lk_priv)));

  p_offset_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok) |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  p_fail_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (rsp_paddr == '0));

  p_fetch_side_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(lk_acc) == 2'd2) |-> (rsp_cause <= 4'd4));

  p_store_perm_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ok && $past(lk_acc) == 2'd1) |-> rsp_perm[1]);

  p_pte_align_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_pte_addr[1:0] == 2'b00));
endmodule

bind tlb_ring_xlate tlb_ring_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .lk_acc       (lk_acc),
  .lk_priv      (lk_priv),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_cause    (rsp_cause),
  .rsp_ring     (rsp_ring),
  .rsp_perm     (rsp_perm),
  .rsp_paddr    (rsp_paddr),
  .rsp_pte_addr (rsp_pte_addr)
);

// File: tb/sim_tlb_ring_xlate.sv
module sim_tlb_ring_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ring_we = 1'b0;
  logic [31:0] ring_wdata = '0;
  logic        ptev_we = 1'b0;
  logic [31:0] ptev_wdata = '0;
  logic        refill_valid = 1'b0;
  logic        refill_is_data = 1'b0;
  logic [31:0] refill_vaddr = '0;
  logic [31:0] refill_pte = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;
  logic [1:0]  lk_priv = '0;
  logic        rsp_valid, rsp_ok;
  logic [3:0]  rsp_cause;
  logic [1:0]  rsp_way, rsp_idx, rsp_ring;
  logic [2:0]  rsp_perm;
  logic [31:0] rsp_paddr, rsp_page_size, rsp_pte_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_ring_xlate u0 (
    .clk(clk), .rst(rst),
    .ring_we(ring_we), .ring_wdata(ring_wdata),
    .ptev_we(ptev_we), .ptev_wdata(ptev_wdata),
    .refill_valid(refill_valid), .refill_is_data(refill_is_data),
    .refill_vaddr(refill_vaddr), .refill_pte(refill_pte),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_priv(lk_priv),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_cause(rsp_cause),
    .rsp_way(rsp_way), .rsp_idx(rsp_idx), .rsp_ring(rsp_ring),
    .rsp_perm(rsp_perm), .rsp_paddr(rsp_paddr),
    .rsp_page_size(rsp_page_size), .rsp_pte_addr(rsp_pte_addr)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] ptev_model = '0;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [1:0]  priv;
    logic [3:0]  cause;
    logic [1:0]  way;
    logic [1:0]  ring;
    logic [2:0]  perm;
    logic [31:0] paddr;
  } vec_t;

  // lookups after six data/instruction refills (see setup below)
  localparam int NVEC = 12;
  localparam vec_t TBL [NVEC] = '{
    '{32'h0000_5123, 2'd0, 2'd0, 4'd0, 2'd1, 2'd0, 3'b111, 32'h1234_5123}, // R2 R7 R9
    '{32'h0000_5FFF, 2'd1, 2'd1, 4'd7, 2'd1, 2'd0, 3'b111, 32'h0},         // R4
    '{32'h0000_6ABC, 2'd1, 2'd1, 4'd0, 2'd2, 2'd1, 3'b110, 32'h00AB_CABC}, // R5 attr 13
    '{32'h0000_6000, 2'd2, 2'd0, 4'd1, 2'd0, 2'd0, 3'b000, 32'h0},         // R3 R10
    '{32'h0000_7010, 2'd2, 2'd2, 4'd0, 2'd3, 2'd2, 3'b101, 32'h0007_7010}, // R5 R6 fetch
    '{32'h0000_7010, 2'd2, 2'd3, 4'd3, 2'd3, 2'd2, 3'b101, 32'h0},         // R4 fetch
    '{32'h0000_9004, 2'd0, 2'd3, 4'd8, 2'd0, 2'd3, 3'b000, 32'h0},         // R6 load deny
    '{32'h0000_9004, 2'd1, 2'd0, 4'd9, 2'd0, 2'd3, 3'b000, 32'h0},         // R6 store deny
    '{32'h0000_8000, 2'd0, 2'd0, 4'd6, 2'd1, 2'd0, 3'b000, 32'h0},         // R3 multi
    '{32'h0000_7010, 2'd0, 2'd0, 4'd5, 2'd0, 2'd0, 3'b000, 32'h0},         // R3 R10
    '{32'h0000_6ABC, 2'd1, 2'd2, 4'd7, 2'd2, 2'd1, 3'b110, 32'h0},         // R4
    '{32'h0000_5123, 2'd2, 2'd0, 4'd1, 2'd0, 2'd0, 3'b000, 32'h0}          // R10
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic write_ring(input logic [31:0] v);
    @(negedge clk); ring_we = 1'b1; ring_wdata = v;
    @(negedge clk); ring_we = 1'b0;
  endtask

  task automatic write_ptev(input logic [31:0] v);
    @(negedge clk); ptev_we = 1'b1; ptev_wdata = v; ptev_model = v;
    @(negedge clk); ptev_we = 1'b0;
  endtask

  task automatic refill(input logic d, input logic [31:0] va, input logic [31:0] pte);
    @(negedge clk);
    refill_valid = 1'b1; refill_is_data = d; refill_vaddr = va; refill_pte = pte;
    @(negedge clk); refill_valid = 1'b0;
  endtask

  // drive at a falling edge, the rising edge registers, sample at the next falling edge
  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_priv = priv;
    @(negedge clk); lk_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input vec_t v);
    logic [31:0] pte_exp;
    pte_exp = (ptev_model | (v.va >> 10)) & ~32'd3;
    chk("R11", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "cause", 32'(rsp_cause), 32'(v.cause));
    chk("R6", "ok", 32'(rsp_ok), 32'(v.cause == 4'd0));
    chk(req, "way", 32'(rsp_way), 32'(v.way));
    chk("R9", "idx", 32'(rsp_idx), 32'(v.va[13:12]));
    chk(req, "ring", 32'(rsp_ring), 32'(v.ring));
    chk("R5", "perm", 32'(rsp_perm), 32'(v.perm));
    chk("R7", "paddr", rsp_paddr, v.paddr);
    chk("R7", "page_size", rsp_page_size, (v.cause == 4'd0) ? 32'd4096 : 32'd0);
    chk("R8", "pte_addr", rsp_pte_addr, pte_exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    lookup(32'h0000_1000, 2'd2, 2'd0);
    expect_rsp("R1", '{32'h0000_1000, 2'd2, 2'd0, 4'd1, 2'd0, 2'd0, 3'b000, 32'h0});
    @(negedge clk);
    chk("R11", "pulse ends", 32'(rsp_valid), 32'd0);
    lookup(32'h0000_1000, 2'd0, 2'd0);
    expect_rsp("R1", '{32'h0000_1000, 2'd0, 2'd0, 4'd5, 2'd0, 2'd0, 3'b000, 32'h0});

    // setup: R8 base, R9 rotation 1,2,3,0,1,2
    write_ptev(32'h8000_0000);
    refill(1'b1, 32'h0000_5000, 32'h1234_5003);  // way1 ring0 attr3
    refill(1'b1, 32'h0000_6000, 32'h00AB_C01D);  // way2 ring1 attr13
    refill(1'b0, 32'h0000_7000, 32'h0007_7021);  // instr way3 ring2 attr1
    refill(1'b1, 32'h0000_9000, 32'h0009_903F);  // way0 ring3 attr15
    refill(1'b1, 32'h0000_8000, 32'h0008_8003);  // way1 idx0
    refill(1'b1, 32'h0000_8000, 32'h0008_8003);  // way2 idx0 -> multi-hit

    for (int i = 0; i < NVEC; i++) begin
      lookup(TBL[i].va, TBL[i].acc, TBL[i].priv);
      expect_rsp("R2-table", TBL[i]);
    end

    // R2: ring follows a rewritten ring register
    write_ring(32'h0102_0304);
    lookup(32'h0000_5123, 2'd0, 2'd3);
    expect_rsp("R2", '{32'h0000_5123, 2'd0, 2'd3, 4'd0, 2'd1, 2'd3, 3'b111, 32'h1234_5123});

    // R2: no byte matches -> ring 3; identifier 0 never hits
    write_ring(32'h0000_0000);
    lookup(32'h0000_5123, 2'd0, 2'd3);
    expect_rsp("R2", '{32'h0000_5123, 2'd0, 2'd3, 4'd0, 2'd1, 2'd3, 3'b111, 32'h1234_5123});
    refill(1'b1, 32'h0000_C000, 32'h000C_C003);  // counter 7 -> way3, ident 0
    lookup(32'h0000_C000, 2'd0, 2'd0);
    expect_rsp("R2", '{32'h0000_C000, 2'd0, 2'd0, 4'd5, 2'd0, 2'd0, 3'b000, 32'h0});

    // R9: counter wraps to way0
    write_ring(32'h0403_0201);
    refill(1'b1, 32'h0000_D000, 32'h000D_D003);
    lookup(32'h0000_D004, 2'd0, 2'd0);
    expect_rsp("R9", '{32'h0000_D004, 2'd0, 2'd0, 4'd0, 2'd0, 2'd0, 3'b111, 32'h000D_D004});

    // R1: reset clears entries, base, counter and ring register
    @(negedge clk); rst = 1'b1; ptev_model = '0;
    repeat (2) @(negedge clk);
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;
    lookup(32'h0000_5123, 2'd0, 2'd0);
    expect_rsp("R1", '{32'h0000_5123, 2'd0, 2'd0, 4'd5, 2'd0, 2'd0, 3'b000, 32'h0});
    refill(1'b1, 32'h0000_E000, 32'h000E_E023);  // ring2 -> ident 3, way1
    lookup(32'h0000_E010, 2'd0, 2'd2);
    expect_rsp("R1", '{32'h0000_E010, 2'd0, 2'd2, 4'd0, 2'd1, 2'd2, 3'b111, 32'h000E_E010});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule